// File: doc/BRIEF.md
# Programmable SPI Frame Master

This block sends one fixed-length frame over SPI to a voltage-regulator device. A single start request loads the transmit word and the configuration. The block then asserts chip select for the whole frame, clocks out the data bits MSB first, and collects MISO bits into a receive word. The SPI clock comes from the system clock through a programmable divider, and all four combinations of clock polarity and clock phase are supported.

Two features tailor the frame to slow or chatty slave devices. The first is an input-delay setting: it holds off MISO capture until a given number of SPI clocks after chip select asserts, so leading bits that the slave has not yet filled never reach the receive word. The second is an enforced gap before the next frame, measured from the end of the last data bit. The gap is always one SPI clock, which is the hold slot with chip select still low. To it the block adds a programmable number of pulses from an external periodic hang-pulse input, counted after chip select rises.

A controller drives `start` for each frame and waits for `done`. The `busy` output shows when a new request would be ignored.

Top module: `spi_frame_master`

## Requirements
- R1: During and right after reset: `spi_cs_n`=1, `busy`=0, `done`=0, `spi_mosi`=0, and `spi_sclk` follows `cfg_cpol`.
- R2: When `start` is high in a cycle where `busy` is low, the block latches `tx_word` and all `cfg_*` inputs. `spi_cs_n` goes low in the next cycle and stays low for (FRAME_BITS+2) slots. Each slot lasts 8*(`cfg_clk_div`+1) system clocks. Slot 0 is setup, slots 1..FRAME_BITS carry data, and slot FRAME_BITS+1 is hold.
- R3: In data slots each half-slot lasts 4*(`cfg_clk_div`+1) cycles. With `cfg_cpha`=0, `spi_sclk` sits at the idle level in the first half and at the active level in the second half. With `cfg_cpha`=1, the active level is in the first half.
- R4: The idle level of `spi_sclk` is low for `cfg_cpol`=0 and high for `cfg_cpol`=1. The active level is its inverse. Outside data slots, and throughout the setup, hold and gap periods, `spi_sclk` stays at the idle level.
- R5: In data slot k, `spi_mosi` carries bit FRAME_BITS-k of the latched word, so the MSB goes first. At all other times it is 0.
- R6: MISO is sampled at the middle of each data slot. The bit of slot k is captured only if k-1 >= `cfg_rx_skip`. Captured bits shift in from the LSB, so the result is right-aligned. Bits not captured read 0, so a skip of FRAME_BITS or more gives 0.
- R7: `done` is high for exactly one cycle: the first cycle with `spi_cs_n` high after a frame. `rx_word` is valid then and is held until the next accepted start.
- R8: With `cfg_gap_pulses`=0, `busy` falls together with `spi_cs_n`. With N>0, `busy` stays high until N cycles with `hang_pulse` high have been seen, counting from the `done` cycle on. It falls in the cycle after the Nth one.
- R9: A `start` while `busy` is high is ignored. Configuration and `tx_word` changes during a frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame request, taken only when idle |
| tx_word | input | FRAME_BITS | Word to transmit, latched at start |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | 0: sample on first edge, 1: on second edge |
| cfg_clk_div | input | DIV_W | SPI period = 8*(value+1) system clocks |
| cfg_rx_skip | input | SKIP_W | Data slots skipped before MISO capture |
| cfg_gap_pulses | input | GAP_W | Extra hang pulses in the inter-frame gap |
| hang_pulse | input | 1 | Periodic timing pulse |
| spi_miso | input | 1 | Serial data from slave |
| busy | output | 1 | Frame or gap in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rx_word | output | FRAME_BITS | Captured data, right-aligned |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to slave |

## Verification
Two pairs of events can land in the same cycle. The first is a hang pulse arriving on the very edge where chip select is released. That pulse must not count toward the gap, while a pulse during the following `done` cycle must count. The bench forces this alignment on one frame, with a two-pulse gap. The second is a start request held high across the gap and into the cycle where the gap expires. It must be ignored until `busy` is low and then taken exactly once. A behavioural model derives every slot and half-slot from a cycle count and the latched settings. It predicts `spi_cs_n`, `spi_sclk`, `spi_mosi`, `busy` and `done` on every clock, so an early or doubled acceptance shows up as a miscompare.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FRAME = 2'd1,
      ST_GAP   = 2'd2
   } fsm_e;
endpackage

// File: rtl/spi_half_timer.sv
// Half-slot prescaler: a half slot lasts 4*(div+1) system clocks.
module spi_half_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             half_end
);
   localparam int CNT_W = DIV_W + 2;

   logic [CNT_W-1:0] tq;

   // 4*(div+1)-1 == {div, 2'b11}; it cannot overflow CNT_W
   assign half_end = run && (tq == {div, 2'b11});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               tq <= '0;
      else if (!run || half_end) tq <= '0;
      else                       tq <= tq + CNT_W'(1);
   end
endmodule

// File: rtl/spi_gap_timer.sv
// Counts hang pulses during the inter-frame gap.
module spi_gap_timer #(
   parameter int GAP_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             active,
   input  logic             hang,
   input  logic [GAP_W-1:0] limit,
   output logic             expire
);
   logic [GAP_W-1:0] cnt;

   assign expire = active && hang && (cnt == (limit - GAP_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clear)          cnt <= '0;
      else if (active && hang) cnt <= cnt + GAP_W'(1);
   end
endmodule

// File: rtl/spi_shift_unit.sv
// Transmit and receive shift registers.
module spi_shift_unit #(
   parameter int FRAME_BITS = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [FRAME_BITS-1:0] tx_in,
   input  logic                  advance,
   input  logic                  capture,
   input  logic                  miso,
   output logic                  tx_msb,
   output logic [FRAME_BITS-1:0] rx_word
);
   logic [FRAME_BITS-1:0] tx_q;
   logic [FRAME_BITS-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tx_q <= '0;
      else if (load)    tx_q <= tx_in;
      else if (advance) tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rx_q <= '0;
      else if (load)    rx_q <= '0;
      else if (capture) rx_q <= {rx_q[FRAME_BITS-2:0], miso};
   end

   assign tx_msb  = tx_q[FRAME_BITS-1];
   assign rx_word = rx_q;
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
   import spi_frame_pkg::*;
#(
   parameter int FRAME_BITS = 32,
   parameter int DIV_W      = 8,
   parameter int SKIP_W     = 6,
   parameter int GAP_W      = 17
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [FRAME_BITS-1:0] tx_word,
   input  logic                  cfg_cpol,
   input  logic                  cfg_cpha,
   input  logic [DIV_W-1:0]      cfg_clk_div,
   input  logic [SKIP_W-1:0]     cfg_rx_skip,
   input  logic [GAP_W-1:0]      cfg_gap_pulses,
   input  logic                  hang_pulse,
   input  logic                  spi_miso,
   output logic                  busy,
   output logic                  done,
   output logic [FRAME_BITS-1:0] rx_word,
   output logic                  spi_cs_n,
   output logic                  spi_sclk,
   output logic                  spi_mosi
);
   localparam int SLOT_W = $clog2(FRAME_BITS + 2);
   localparam int CMP_W  = ((SLOT_W > SKIP_W) ? SLOT_W : SKIP_W) + 1;
   localparam logic [SLOT_W-1:0] DATA_LAST = SLOT_W'(FRAME_BITS);
   localparam logic [SLOT_W-1:0] HOLD_SLOT = SLOT_W'(FRAME_BITS + 1);

   if (FRAME_BITS < 2) begin : g_bad_frame
      $error("FRAME_BITS must be at least 2");
   end
   if (DIV_W < 1 || SKIP_W < 1 || GAP_W < 1) begin : g_bad_width
      $error("DIV_W, SKIP_W and GAP_W must be at least 1");
   end

   fsm_e              state;
   logic              ph;
   logic [SLOT_W-1:0] slot;
   logic              done_q;
   logic [DIV_W-1:0]  div_q;
   logic              cpol_q, cpha_q;
   logic [SKIP_W-1:0] skip_q;
   logic [GAP_W-1:0]  gap_q;

   logic accept, half_end, mid_pt, slot_end, hold_end;
   logic data_slot, capture, gap_expire, tx_msb;

   assign accept    = (state == ST_IDLE) && start;
   assign mid_pt    = half_end && !ph;
   assign slot_end  = half_end && ph;
   assign hold_end  = slot_end && (slot == HOLD_SLOT);
   assign data_slot = (state == ST_FRAME) && (slot != '0) && (slot <= DATA_LAST);
   assign capture   = mid_pt && data_slot && (CMP_W'(slot) > CMP_W'(skip_q));

   spi_half_timer #(.DIV_W(DIV_W)) u_half (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (state == ST_FRAME),
      .div      (div_q),
      .half_end (half_end)
   );

   spi_gap_timer #(.GAP_W(GAP_W)) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (hold_end),
      .active (state == ST_GAP),
      .hang   (hang_pulse),
      .limit  (gap_q),
      .expire (gap_expire)
   );

   spi_shift_unit #(.FRAME_BITS(FRAME_BITS)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .tx_in   (tx_word),
      .advance (slot_end && data_slot),
      .capture (capture),
      .miso    (spi_miso),
      .tx_msb  (tx_msb),
      .rx_word (rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         ph     <= 1'b0;
         slot   <= '0;
         done_q <= 1'b0;
         div_q  <= '0;
         cpol_q <= 1'b0;
         cpha_q <= 1'b0;
         skip_q <= '0;
         gap_q  <= '0;
      end else begin
         done_q <= hold_end;
         unique case (state)
            ST_IDLE: if (accept) begin
               state  <= ST_FRAME;
               ph     <= 1'b0;
               slot   <= '0;
               div_q  <= cfg_clk_div;
               cpol_q <= cfg_cpol;
               cpha_q <= cfg_cpha;
               skip_q <= cfg_rx_skip;
               gap_q  <= cfg_gap_pulses;
            end
            ST_FRAME: begin
               if (half_end) ph <= ~ph;
               if (hold_end)      state <= (gap_q == '0) ? ST_IDLE : ST_GAP;
               else if (slot_end) slot  <= slot + SLOT_W'(1);
            end
            ST_GAP: if (gap_expire) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic idle_lvl, act_half;
   always_comb begin
      idle_lvl = (state == ST_IDLE) ? cfg_cpol : cpol_q;
      act_half = cpha_q ? !ph : ph;
      spi_sclk = idle_lvl ^ (data_slot && act_half);
   end

   assign spi_mosi = data_slot && tx_msb;
   assign spi_cs_n = (state != ST_FRAME);
   assign busy     = (state != ST_IDLE);
   assign done     = done_q;
endmodule

// File: rtl/spi_frame_master_chk.sv
module spi_frame_master_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic cfg_cpol,
   input logic busy,
   input logic done,
   input logic spi_cs_n,
   input logic spi_sclk,
   input logic spi_mosi
);
   AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (spi_cs_n && $past(!spi_cs_n)));                       // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                // R7
   AST_MOSI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_mosi);                                        // R5
   AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (spi_sclk == cfg_cpol));                              // R4
   AST_CS_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n && $past(spi_cs_n)) |-> $past(start && !busy));      // R9
   AST_GAP_SCLK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && spi_cs_n && $past(busy)) |-> $stable(spi_sclk));      // R8
endmodule

bind spi_frame_master spi_frame_master_chk u_chk (.*);

// File: tb/spi_frame_master_test.sv
`timescale 1ns/1ps
module spi_frame_master_test;
   localparam int FB = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [FB-1:0] tx_word = '0;
   logic          cfg_cpol = 1'b1;
   logic          cfg_cpha = 1'b0;
   logic [7:0]    cfg_clk_div = '0;
   logic [5:0]    cfg_rx_skip = '0;
   logic [16:0]   cfg_gap_pulses = '0;
   logic          hang_auto = 1'b0, hang_force = 1'b0;
   logic          hang_pulse;
   logic          spi_miso = 1'b0;
   logic          busy, done, spi_cs_n, spi_sclk, spi_mosi;
   logic [FB-1:0] rx_word;

   assign hang_pulse = hang_auto | hang_force;

   always #2 clk = ~clk;   // 250 MHz

   spi_frame_master #(.FRAME_BITS(FB), .DIV_W(8), .SKIP_W(6), .GAP_W(17)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
      .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_clk_div(cfg_clk_div),
      .cfg_rx_skip(cfg_rx_skip), .cfg_gap_pulses(cfg_gap_pulses),
      .hang_pulse(hang_pulse), .spi_miso(spi_miso), .busy(busy), .done(done),
      .rx_word(rx_word), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
   );

   int vecs = 0, errs = 0, cyc = 0;
   bit chk_en = 0;

   // behavioural reference state
   int m_state = 0, m_t = 0, m_p = 0, m_div = 0, m_dly = 0, m_gap = 0;
   bit m_done = 0, m_cpol = 0, m_cpha = 0;
   logic [FB-1:0] m_tx = '0, m_pat = '0, pat_cur = '0;

   task automatic chk(input string tag, input string what,
                      input logic [FB-1:0] act, input logic [FB-1:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   function automatic logic [FB-1:0] exp_rx(input logic [FB-1:0] p, input int d);
      if (d >= FB) return '0;
      return FB'(64'(p) & ((64'd1 << (FB - d)) - 64'd1));
   endfunction

   function automatic int frame_cycles(input int div);
      return (FB + 2) * 8 * (div + 1);
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errs++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
      if (!rst_n) begin
         m_state = 0; m_done = 0; m_t = 0; m_p = 0;
      end else begin
         m_done = 0;
         case (m_state)
            0: if (start) begin
               m_state = 1; m_t = 0; m_tx = tx_word; m_pat = pat_cur;
               m_div = int'(cfg_clk_div); m_cpol = cfg_cpol; m_cpha = cfg_cpha;
               m_dly = int'(cfg_rx_skip); m_gap = int'(cfg_gap_pulses);
            end
            1: if (m_t == frame_cycles(m_div) - 1) begin
               m_done = 1; m_p = 0; m_state = (m_gap == 0) ? 0 : 2;
            end else m_t++;
            default: if (hang_pulse) begin
               m_p++;
               if (m_p == m_gap) m_state = 0;
            end
         endcase
      end
   end

   // compare every cycle, away from both edges; also drive slave MISO and hang pulses
   always @(negedge clk) begin
      #1;
      begin
         int h, slot, ph;
         bit dslot;
         logic exp_sclk, exp_mosi;
         h = 4 * (m_div + 1);
         slot = m_t / (2 * h);
         ph = (m_t / h) % 2;
         dslot = (m_state == 1) && slot >= 1 && slot <= FB;
         exp_sclk = dslot ? (m_cpol ^ (m_cpha ? !ph[0] : ph[0]))
                          : ((m_state == 0) ? cfg_cpol : m_cpol);
         exp_mosi = dslot ? m_tx[FB - slot] : 1'b0;
         if (chk_en) begin
            chk("R2", "cs_n", FB'(spi_cs_n), FB'(m_state != 1));
            chk(dslot ? "R3" : "R4", "sclk", FB'(spi_sclk), FB'(exp_sclk));
            chk("R5", "mosi", FB'(spi_mosi), FB'(exp_mosi));
            chk("R8", "busy", FB'(busy), FB'(m_state != 0));
            chk("R7", "done", FB'(done), FB'(m_done));
            if (m_done) chk("R6", "rx_word", rx_word, exp_rx(m_pat, m_dly));
         end
         spi_miso = dslot ? m_pat[FB - slot] : 1'b0;
         hang_auto = (cyc % 5 == 2);
      end
   end

   task automatic run_frame(input logic [FB-1:0] tx, input logic [FB-1:0] pat,
                            input int div, input bit cpol, input bit cpha,
                            input int dly, input int gap,
                            input bit stray, input bit force_hang);
      int fc;
      fc = frame_cycles(div);
      @(negedge clk);
      tx_word = tx; pat_cur = pat; cfg_clk_div = 8'(div); cfg_cpol = cpol;
      cfg_cpha = cpha; cfg_rx_skip = 6'(dly); cfg_gap_pulses = 17'(gap);
      start = 1'b1;                       // may be held across a previous gap
      do @(negedge clk); while (m_state != 1);
      start = 1'b0;
      // R9: settings and word changed mid-frame must not disturb it
      cfg_clk_div = cfg_clk_div + 8'd3; cfg_cpha = ~cfg_cpha; tx_word = ~tx;
      cfg_rx_skip = 6'd0; cfg_gap_pulses = 17'd0;
      if (stray) begin
         repeat (40) @(negedge clk);
         start = 1'b1;                    // R9: request while busy
         @(negedge clk);
         start = 1'b0;
      end
      do begin
         @(negedge clk);
         if (force_hang && m_state == 1 && m_t == fc - 1) hang_force = 1'b1;
      end while (m_state == 1);
      @(negedge clk);
      hang_force = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state, idle clock follows polarity input
      chk("R1", "cs_n", FB'(spi_cs_n), FB'(1));
      chk("R1", "busy", FB'(busy), FB'(0));
      chk("R1", "done", FB'(done), FB'(0));
      chk("R1", "mosi", FB'(spi_mosi), FB'(0));
      chk("R1", "sclk", FB'(spi_sclk), FB'(1));
      @(negedge clk);
      rst_n = 1'b1;
      chk_en = 1;
      run_frame(32'hA5C3_0F96, 32'h1234_5678, 0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
      run_frame(32'h8000_0001, 32'hFFFF_FFFF, 1, 1'b1, 1'b0, 5, 2, 1'b0, 1'b0);
      run_frame(32'h0F0F_F0F0, 32'hDEAD_BEEF, 0, 1'b0, 1'b1, 32, 0, 1'b1, 1'b0);
      repeat (20) @(negedge clk);
      #1;
      chk("R9", "cs_n after stray start", FB'(spi_cs_n), FB'(1));
      chk("R9", "busy after stray start", FB'(busy), FB'(0));
      // hang pulse on the releasing edge and in the done cycle
      run_frame(32'h6B2D_91E4, 32'hCAFE_F00D, 2, 1'b1, 1'b1, 31, 2, 1'b0, 1'b1);
      // start held through the gap of the previous frame
      run_frame(32'h1357_9BDF, 32'h2468_ACE0, 0, 1'b0, 1'b1, 33, 1, 1'b0, 1'b0);
      while (m_state != 0) @(negedge clk);
      repeat (5) @(negedge clk);
      #1;
      chk("R7", "idle after last frame", FB'(busy), FB'(0));
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule